// File: doc/BRIEF.md
# Strobed Synthesizer Configuration Selector

This block picks one of 32 preset clock-synthesizer configurations from a 5-bit select input and a level-sensitive strobe. Both inputs are brought into the system clock domain through a two-stage synchronizer. While the synchronized strobe is high, the select value sets the active table address directly. While it is low, the select lines are ignored and the address last taken with the strobe high stays in force. Coming out of reset with the strobe low, the active address is entry 0.

Each table entry is a registered configuration word with four fields: a feedback divide value, a reference divide value, a VCO gain code and a post-divide setting. The table is a constant array computed at elaboration. Because the word is registered, all four fields change on the same clock edge. Every rising edge of the synchronized strobe also produces a one-cycle pulse on `pipe_rst_pulse`. Downstream logic uses this pulse to restart its output pipeline.

Top module: `freq_sel_table`

## Requirements
- R1: `sel_in` is 5 bits wide and addresses 32 entries. `active_addr` shows the address currently in force, and `cfg_*` show the word stored at that address.
- R2: While `strobe_in` is held high, a new `sel_in` value appears on `active_addr` after the third rising clock edge and on the `cfg_*` outputs after the fourth.
- R3: While the synchronized strobe is low, changes on `sel_in` have no effect on `active_addr` or `cfg_*`. The address taken from the last synchronized sample with the strobe high is held, including when `sel_in` changes in the same cycle that the strobe falls.
- R4: After reset is released with `strobe_in` low, `active_addr` is 0 and `cfg_*` hold entry 0, whatever the value of `sel_in`.
- R5: For entry i:
  - `cfg_fb` = 100 + 9*i (10 bits)
  - `cfg_ref` = 2 + (i mod 13) (5 bits)
  - `cfg_gain` = (3*i) mod 8 (3 bits)
  - `cfg_post` = i div 8 (2 bits)
- R6: Each 0-to-1 transition of `strobe_in` produces exactly one `pipe_rst_pulse` that is high for one cycle. It starts after the third rising clock edge that follows the transition. No pulse is produced while the strobe stays high or stays low.
- R7: The four `cfg_*` fields change together on a single clock edge. They stay unchanged in any cycle that follows a cycle in which `active_addr` did not change.
- R8: While `rst` is high, `active_addr` reads 0 and `pipe_rst_pulse` reads 0. The synchronizer treats the strobe as low during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_in | input | 5 | Asynchronous table select |
| strobe_in | input | 1 | Asynchronous strobe: high passes the select, low holds it |
| active_addr | output | 5 | Table address in force |
| cfg_fb | output | 10 | Feedback divide value |
| cfg_ref | output | 5 | Reference divide value |
| cfg_gain | output | 3 | VCO gain code |
| cfg_post | output | 2 | Post-divide setting |
| pipe_rst_pulse | output | 1 | One-cycle pulse on each strobe rise |

## Verification
Some rules are checked by assertions on every cycle:
- the held address does not move while the synchronized strobe is low;
- the address follows the synchronized select while the strobe is high;
- the pulse lasts one cycle and comes only after a low strobe sample;
- the configuration word stays put when the address did not move.

Other behaviour can only be shown by the bench's scenarios at the ports. These scenarios cover the exact latency from the pins, the field values of all 32 entries, the power-up default to entry 0 with the select at all ones, capture at the cycle the strobe falls together with a select change, and the count of pulses per strobe rise.

// File: rtl/fst_pkg.sv
package fst_pkg;

  localparam int FB_W   = 10;
  localparam int REF_W  = 5;
  localparam int GAIN_W = 3;
  localparam int POST_W = 2;

  typedef struct packed {
    logic [FB_W-1:0]   fb;
    logic [REF_W-1:0]  rdiv;
    logic [GAIN_W-1:0] gain;
    logic [POST_W-1:0] post;
  } synth_cfg_t;

  // Preset contents, computed rather than listed.
  function automatic synth_cfg_t entry_of(input int idx);
    synth_cfg_t c;
    c.fb   = FB_W'(100 + 9 * idx);
    c.rdiv = REF_W'(2 + (idx % 13));
    c.gain = GAIN_W'((3 * idx) % 8);
    c.post = POST_W'(idx / 8);
    return c;
  endfunction

endpackage

// File: rtl/fst_sync.sv
module fst_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= '0;
    end else begin
      stage[0] <= d;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/fst_addr_hold.sv
module fst_addr_hold #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] sel_s,
  input  logic          stb_s,
  output logic [AW-1:0] addr_q,
  output logic          pulse_q
);
  logic stb_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      stb_d   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (stb_s) addr_q <= sel_s;
      stb_d   <= stb_s;
      pulse_q <= stb_s & ~stb_d;
    end
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !stb_s |=> addr_q == $past(addr_q));
  p_pass_r2: assert property (@(posedge clk) disable iff (rst)
    stb_s |=> addr_q == $past(sel_s));
  p_pulse_width_r6: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> !pulse_q);
  p_pulse_after_low_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_q) |-> !$past(stb_d));
  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (addr_q == '0) && !pulse_q);
endmodule

// File: rtl/fst_cfg_rom.sv
module fst_cfg_rom
  import fst_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output synth_cfg_t    cfg_q
);
  synth_cfg_t rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_fill
    assign rom[g] = entry_of(g);
  end

  // Registered read, no reset: maps onto a block RAM output register.
  always_ff @(posedge clk) cfg_q <= rom[addr];
endmodule

// File: rtl/freq_sel_table.sv
module freq_sel_table
  import fst_pkg::*;
#(
  parameter int SEL_W       = 5,
  parameter int SYNC_STAGES = 2,
  localparam int DEPTH      = 1 << SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  sel_in,
  input  logic              strobe_in,
  output logic [SEL_W-1:0]  active_addr,
  output logic [FB_W-1:0]   cfg_fb,
  output logic [REF_W-1:0]  cfg_ref,
  output logic [GAIN_W-1:0] cfg_gain,
  output logic [POST_W-1:0] cfg_post,
  output logic              pipe_rst_pulse
);
  logic [SEL_W:0]   raw_in, sync_out;
  logic [SEL_W-1:0] addr;
  synth_cfg_t       word;

  assign raw_in = {strobe_in, sel_in};

  fst_sync #(.W(SEL_W + 1), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(sync_out)
  );

  fst_addr_hold #(.AW(SEL_W)) u_hold (
    .clk(clk), .rst(rst),
    .sel_s(sync_out[SEL_W-1:0]), .stb_s(sync_out[SEL_W]),
    .addr_q(addr), .pulse_q(pipe_rst_pulse)
  );

  fst_cfg_rom #(.DEPTH(DEPTH)) u_rom (
    .clk(clk), .addr(addr), .cfg_q(word)
  );

  assign active_addr = addr;
  assign cfg_fb      = word.fb;
  assign cfg_ref     = word.rdiv;
  assign cfg_gain    = word.gain;
  assign cfg_post    = word.post;

  p_word_stable_r7: assert property (@(posedge clk) disable iff (rst)
    $stable(active_addr) |=> $stable({cfg_fb, cfg_ref, cfg_gain, cfg_post}));
endmodule

// File: tb/test_freq_sel_table.sv
module test_freq_sel_table;
  logic       clk = 1'b0;
  logic       rst;
  logic [4:0] sel_in;
  logic       strobe_in;
  logic [4:0] active_addr;
  logic [9:0] cfg_fb;
  logic [4:0] cfg_ref;
  logic [2:0] cfg_gain;
  logic [1:0] cfg_post;
  logic       pipe_rst_pulse;

  int vectors = 0;
  int errors  = 0;
  int pulses  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  freq_sel_table i_freq_sel_table (
    .clk(clk), .rst(rst), .sel_in(sel_in), .strobe_in(strobe_in),
    .active_addr(active_addr), .cfg_fb(cfg_fb), .cfg_ref(cfg_ref),
    .cfg_gain(cfg_gain), .cfg_post(cfg_post), .pipe_rst_pulse(pipe_rst_pulse)
  );

  always @(negedge clk) if (!rst && pipe_rst_pulse) pulses++;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected word from the R5 formulas, packed as fb,ref,gain,post.
  task automatic chk_entry(input string req, input int i);
    chk({req, " fb"},   int'(cfg_fb),   100 + 9 * i);
    chk({req, " ref"},  int'(cfg_ref),  2 + (i % 13));
    chk({req, " gain"}, int'(cfg_gain), (3 * i) % 8);
    chk({req, " post"}, int'(cfg_post), i / 8);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; sel_in = 5'd31; strobe_in = 1'b0;
    tick(3);
    chk("R8 addr in reset", active_addr, 0);
    chk("R8 pulse in reset", pipe_rst_pulse, 0);
    rst = 1'b0;
    tick(6);
    chk("R4 power-up addr", active_addr, 0);
    chk_entry("R4 power-up word", 0);
    chk("R4 no pulse", pulses, 0);

    // R2/R7/R6: exact latency from the pins
    sel_in = 5'd5; strobe_in = 1'b1;
    tick(2);
    chk("R2 addr not yet", active_addr, 0);
    tick(1);
    chk("R2 addr at edge 3", active_addr, 5);
    chk_entry("R7 old word at edge 3", 0);
    chk("R6 pulse at edge 3", pipe_rst_pulse, 1);
    tick(1);
    chk_entry("R7 new word at edge 4", 5);
    chk("R6 pulse gone", pipe_rst_pulse, 0);

    // R1/R5: full sweep in transparent mode
    for (int i = 0; i < 32; i++) begin
      sel_in = 5'(i);
      tick(5);
      chk("R1 addr", active_addr, i);
      chk_entry("R5 entry", i);
    end

    // R3: hold while strobe low
    sel_in = 5'd9; tick(5);
    strobe_in = 1'b0; tick(5);
    for (int j = 0; j < 32; j++) begin
      sel_in = 5'(j);
      tick(4);
      chk("R3 held addr", active_addr, 9);
      chk_entry("R3 held word", 9);
    end

    // R3: select changes in the cycle the strobe falls
    sel_in = 5'd20; strobe_in = 1'b1; tick(5);
    sel_in = 5'd21; strobe_in = 1'b0; tick(6);
    chk("R3 capture at fall", active_addr, 20);
    chk_entry("R3 capture word", 20);

    // R6: one pulse per rise, none while steady
    pulses = 0;
    for (int k = 0; k < 3; k++) begin
      strobe_in = 1'b1; tick(6);
      strobe_in = 1'b0; tick(6);
    end
    chk("R6 pulse count", pulses, 3);
    strobe_in = 1'b1; tick(20);
    chk("R6 steady high count", pulses, 4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule